// File: doc/BRIEF.md
# Time-Domain Driven Square-Wave Pin Generator

This block drives one output pin from a time domain's nanosecond count. When the pin is armed for waveform output and the domain is running, the pin produces a square wave. The wave is built from two programmed durations, one for the low time and one for the high time, both in nanoseconds. Two shaping modes are available. Free mode alternates low and high for as long as the pin stays armed. Second-aligned mode produces one pulse per second: the pin rises a programmed delay after each second boundary and stays high for a programmed width.

The block watches the nanosecond value and the second-rollover tick that the time domain supplies. It does not keep time itself. In free mode it adds up the nanoseconds that pass each cycle and carries the overshoot past each edge into the next segment, so the edges do not drift when the clock step does not divide the segment lengths. Start times within the second are set only as a phase offset. The block has no absolute start time.

Top module: `ptp_pin_wavegen`

## Requirements
- R1: While reset is held, and in the first cycle after it, `pin_out` is low.
- R2: `pin_out` is low unless `dom_en` is 1 and `pin_action` is 1 (the waveform action). The other action values are 0 (idle), 2 and 3, and all of them hold the pin low.
- R3: When `high_ns` is 0, `pin_out` stays low in both shaping modes.
- R4: Free mode is any `sync_mode` other than 3. Let t be the nanoseconds elapsed since the first active free cycle, and P = `low_ns` + `high_ns`. The pin is high exactly when t mod P >= `low_ns`. The first active cycle itself is low.
- R5: In free mode each edge lands on the first cycle whose elapsed time reaches the edge's target. The overshoot is carried into the next segment, so after many periods the edges follow the arithmetic of R4 with no accumulated error.
- R6: Free mode counts time across a second rollover. In the cycle where `dom_sec_tick` is 1, the elapsed time grows by `dom_ns` + NS_PER_SEC minus the previous `dom_ns`.
- R7: With `sync_mode` = 3 (second-aligned mode), the pin is high when `low_ns` <= `dom_ns` < `low_ns` + `high_ns`, and low otherwise.
- R8: In second-aligned mode, a pulse whose window passes the end of the second is cut at the rollover. Nothing of it carries into the next second.
- R9: Entering free mode, whether from inactive or from second-aligned mode, restarts the free wave from its low segment with zero elapsed time.
- R10: `pin_out` is registered. It reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dom_en | input | 1 | Time domain running |
| dom_ns | input | NS_W | Domain nanoseconds within the current second |
| dom_sec_tick | input | 1 | High in the cycle where `dom_ns` has wrapped to a new second |
| pin_action | input | 2 | Pin action: 0 idle, 1 waveform, 2 and 3 inactive |
| sync_mode | input | 2 | 3 selects second-aligned mode; any other value selects free mode |
| low_ns | input | NS_W | Low time (free mode) or delay after the second boundary (second-aligned mode) |
| high_ns | input | NS_W | High time (free mode) or pulse width (second-aligned mode) |
| pin_out | output | 1 | Pin level |

## Verification
The free-mode sweep uses low and high times that the clock step does not divide. A design that cleared its remainder at each edge would then drift away from the modulo arithmetic within a few periods. One run starts just before a second rollover. A design that ignored the rollover tick would see a huge or negative step and flip the pin at the wrong time. Second-aligned runs include a window that crosses the end of the second, which catches a pulse that leaks into the next second. A zero width catches a design that emits a one-cycle glitch. The mode-switch and idle runs catch a free wave that resumes mid-segment when it should restart low.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;
  typedef enum logic [1:0] {
    PA_IDLE  = 2'd0,
    PA_CLOCK = 2'd1
  } pin_action_e;

  localparam logic [1:0] SYNC_SECOND = 2'd3;

  // Nanoseconds elapsed between two samples of the domain counter.
  function automatic logic [31:0] ns_step(input logic [31:0] prev_ns,
                                          input logic [31:0] cur_ns,
                                          input logic        wrapped,
                                          input logic [31:0] ns_per_sec);
    ns_step = wrapped ? (cur_ns + ns_per_sec - prev_ns) : (cur_ns - prev_ns);
  endfunction

  // True when ns lies in [start, start+width) of the current second.
  function automatic logic in_window(input logic [31:0] ns,
                                     input logic [31:0] start,
                                     input logic [31:0] width);
    in_window = (width != 32'd0) && (ns >= start) && (ns < start + width);
  endfunction
endpackage

// File: rtl/wg_ns_delta.sv
module wg_ns_delta #(
  parameter int NS_PER_SEC = 1000000000,
  parameter int NS_W       = 30,
  parameter int ACC_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NS_W-1:0]  cur_ns,
  input  logic             sec_tick,
  output logic [ACC_W-1:0] delta_ns
);
  import wavegen_pkg::*;

  logic [NS_W-1:0] prev_ns_q;
  logic [31:0]     step_w;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_ns_q <= '0;
    else        prev_ns_q <= cur_ns;
  end

  assign step_w   = ns_step(32'(prev_ns_q), 32'(cur_ns), sec_tick, 32'(NS_PER_SEC));
  assign delta_ns = ACC_W'(step_w);

  AST_DELTA_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> delta_ns <= ACC_W'(NS_PER_SEC)); // R6
endmodule

// File: rtl/wg_free_seq.sv
module wg_free_seq #(
  parameter int NS_W  = 30,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             start,
  input  logic [ACC_W-1:0] delta_ns,
  input  logic [NS_W-1:0]  low_ns,
  input  logic [NS_W-1:0]  high_ns,
  output logic             level_nxt
);
  logic             seg_q;      // 0 low segment, 1 high segment
  logic [ACC_W-1:0] elapsed_q;
  logic [ACC_W-1:0] acc_w;
  logic [ACC_W-1:0] seg_len_w;
  logic             cross_w;
  logic             hold_w;

  assign acc_w     = elapsed_q + delta_ns;
  assign seg_len_w = seg_q ? ACC_W'(high_ns) : ACC_W'(low_ns);
  assign cross_w   = acc_w >= seg_len_w;
  assign hold_w    = !run || start || (high_ns == '0);
  assign level_nxt = hold_w ? 1'b0 : (cross_w ? ~seg_q : seg_q);

  always_ff @(posedge clk) begin
    if (!rst_n || hold_w) begin
      seg_q     <= 1'b0;
      elapsed_q <= '0;
    end else if (cross_w) begin
      seg_q     <= ~seg_q;
      elapsed_q <= acc_w - seg_len_w;
    end else begin
      elapsed_q <= acc_w;
    end
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !seg_q && elapsed_q == '0); // R9
  AST_SEG_ON_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && high_ns != '0 && !cross_w) |=> $stable(seg_q)); // R5
endmodule

// File: rtl/wg_second_gate.sv
module wg_second_gate #(
  parameter int NS_W = 30
) (
  input  logic [NS_W-1:0] cur_ns,
  input  logic [NS_W-1:0] low_ns,
  input  logic [NS_W-1:0] high_ns,
  output logic            level
);
  import wavegen_pkg::*;
  assign level = in_window(32'(cur_ns), 32'(low_ns), 32'(high_ns));
endmodule

// File: rtl/ptp_pin_wavegen.sv
module ptp_pin_wavegen #(
  parameter int NS_PER_SEC = 1000000000,
  parameter int NS_W       = $clog2(NS_PER_SEC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dom_en,
  input  logic [NS_W-1:0] dom_ns,
  input  logic            dom_sec_tick,
  input  logic [1:0]      pin_action,
  input  logic [1:0]      sync_mode,
  input  logic [NS_W-1:0] low_ns,
  input  logic [NS_W-1:0] high_ns,
  output logic            pin_out
);
  import wavegen_pkg::*;
  localparam int ACC_W = NS_W + 2;

  logic             active_w;
  logic             second_w;
  logic             free_run_w;
  logic             free_q;
  logic             free_start_w;
  logic [ACC_W-1:0] delta_w;
  logic             free_lvl_w;
  logic             sec_lvl_w;
  logic             pin_d;

  assign active_w     = dom_en && (pin_action == PA_CLOCK);
  assign second_w     = (sync_mode == SYNC_SECOND);
  assign free_run_w   = active_w && !second_w;
  assign free_start_w = free_run_w && !free_q;

  wg_ns_delta #(.NS_PER_SEC(NS_PER_SEC), .NS_W(NS_W), .ACC_W(ACC_W)) delta_i (
    .clk(clk), .rst_n(rst_n), .cur_ns(dom_ns), .sec_tick(dom_sec_tick),
    .delta_ns(delta_w));

  wg_free_seq #(.NS_W(NS_W), .ACC_W(ACC_W)) free_i (
    .clk(clk), .rst_n(rst_n), .run(free_run_w), .start(free_start_w),
    .delta_ns(delta_w), .low_ns(low_ns), .high_ns(high_ns),
    .level_nxt(free_lvl_w));

  wg_second_gate #(.NS_W(NS_W)) sec_i (
    .cur_ns(dom_ns), .low_ns(low_ns), .high_ns(high_ns), .level(sec_lvl_w));

  assign pin_d = active_w && (second_w ? sec_lvl_w : free_lvl_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q  <= 1'b0;
      pin_out <= 1'b0;
    end else begin
      free_q  <= free_run_w;
      pin_out <= pin_d;
    end
  end

  AST_INACTIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !active_w |=> !pin_out); // R2
  AST_ZERO_WIDTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (high_ns == '0) |=> !pin_out); // R3
  AST_SECOND_EARLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (second_w && dom_ns < low_ns) |=> !pin_out); // R7
  AST_SECOND_LATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (second_w && ({1'b0, dom_ns} >= {1'b0, low_ns} + {1'b0, high_ns})) |=> !pin_out); // R8
  AST_FREE_ENTRY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    free_start_w |=> !pin_out); // R9
endmodule

// File: tb/ptp_pin_wavegen_tb_top.sv
module ptp_pin_wavegen_tb_top;
  localparam int NSPS = 1000;
  localparam int NSW  = $clog2(NSPS);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           dom_en = 1'b0;
  logic [NSW-1:0] dom_ns = '0;
  logic           dom_sec_tick = 1'b0;
  logic [1:0]     pin_action = 2'd0;
  logic [1:0]     sync_mode = 2'd0;
  logic [NSW-1:0] low_ns = '0;
  logic [NSW-1:0] high_ns = '0;
  logic           pin_out;

  int checks = 0;
  int errors = 0;
  int step_ns = 4;
  int j_cyc = 0;
  bit prev_free = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  ptp_pin_wavegen #(.NS_PER_SEC(NSPS)) dut_i (
    .clk(clk), .rst_n(rst_n), .dom_en(dom_en), .dom_ns(dom_ns),
    .dom_sec_tick(dom_sec_tick), .pin_action(pin_action), .sync_mode(sync_mode),
    .low_ns(low_ns), .high_ns(high_ns), .pin_out(pin_out));

  task automatic check(input bit exp, input string req);
    checks++;
    if (pin_out !== exp) begin
      errors++;
      $display("FAIL %s: pin_out=%b expected=%b at t=%0t", req, pin_out, exp, $time);
    end
  endtask

  // Expected level from the requirements for the inputs now applied.
  function automatic bit model();
    bit act;
    bit fr;
    int p;
    act = (pin_action == 2'd1) && dom_en;
    fr  = act && (sync_mode != 2'd3);
    if (fr) j_cyc = prev_free ? j_cyc + 1 : 0;
    prev_free = fr;
    if (!act || high_ns == 0) return 1'b0;
    if (sync_mode == 2'd3)
      return (int'(dom_ns) >= int'(low_ns)) && (int'(dom_ns) < int'(low_ns) + int'(high_ns));
    if (j_cyc == 0) return 1'b0;
    p = int'(low_ns) + int'(high_ns);
    return ((j_cyc * step_ns) % p) >= int'(low_ns);
  endfunction

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      bit exp;
      int nx;
      exp = model();
      @(posedge clk); #1;
      check(exp, req);
      nx = int'(dom_ns) + step_ns;
      dom_sec_tick = (nx >= NSPS);
      if (nx >= NSPS) nx -= NSPS;
      dom_ns = NSW'(nx);
    end
  endtask

  task automatic cfg(input bit en, input int act, input int sy, input int lo, input int hi);
    dom_en = en; pin_action = 2'(act); sync_mode = 2'(sy);
    low_ns = NSW'(lo); high_ns = NSW'(hi);
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lo_set[4] = '{4, 10, 13, 40};
    int hi_set[3] = '{4, 7, 25};
    int slo[3] = '{0, 100, 900};
    int shi[3] = '{0, 50, 200};
    repeat (3) @(posedge clk);
    #1 check(1'b0, "R1 during reset");
    cfg(1'b1, 1, 0, 10, 7);
    @(posedge clk); #1;
    check(1'b0, "R1 during reset with active config");
    rst_n = 1'b1;
    cfg(1'b0, 0, 0, 10, 7);
    run(2, "R1 after reset");
    // Free-mode sweep with non-dividing step (R4, R5)
    foreach (lo_set[a]) foreach (hi_set[b]) begin
      cfg(1'b1, 1, 0, lo_set[a], hi_set[b]);
      run(300, "R4 R5 free sweep");
      cfg(1'b1, 0, 0, lo_set[a], hi_set[b]);
      run(3, "R2 idle action");
    end
    // Rollover in free mode with a step of 12 (R6)
    step_ns = 12;
    dom_ns = NSW'(980);
    cfg(1'b1, 1, 1, 13, 25);
    run(400, "R6 free across rollover");
    step_ns = 4;
    // Other inactive encodings and domain off (R2)
    cfg(1'b1, 2, 0, 13, 25); run(20, "R2 action 2");
    cfg(1'b1, 3, 3, 0, 500); run(20, "R2 action 3");
    cfg(1'b0, 1, 0, 13, 25); run(20, "R2 domain disabled");
    // Zero high time in both modes (R3)
    cfg(1'b1, 1, 0, 13, 0); run(50, "R3 free zero width");
    cfg(1'b1, 1, 3, 13, 0); run(300, "R3 second zero width");
    // Second-aligned sweep (R7, R8 via 900+200)
    foreach (slo[a]) foreach (shi[b]) begin
      cfg(1'b1, 1, 3, slo[a], shi[b]);
      run(600, (slo[a] + shi[b] > NSPS) ? "R8 cut at rollover" : "R7 second window");
    end
    // Switching second-aligned -> free restarts low (R9), latency R10
    cfg(1'b1, 1, 3, 0, 900); run(30, "R10 registered second");
    cfg(1'b1, 1, 0, 10, 7); run(100, "R9 restart after mode switch");
    cfg(1'b1, 0, 0, 10, 7); run(1, "R9 idle gap");
    cfg(1'b1, 1, 0, 10, 7); run(100, "R9 restart after idle");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule